// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Request Unit

This unit gathers interrupt requests from a parameterized set of devices. Each device offers a ready flag, an enable flag, a fixed priority level (0 is the least urgent and 7 the most urgent at the default width) and an 8-bit vector. A device is a candidate only while both of its flags are set. Among the candidates the unit picks the one with the highest level and raises a single interrupt request when that level is strictly above the level of the program that is running.

The processor's control sequencer pulses `fetch_first` in the first cycle of each instruction fetch. The request is acted on only in that cycle. When it is taken, the `take` output tells the sequencer to go to interrupt handling instead of a normal fetch. The winner's vector and level are stored and held for the interrupt entry sequence until that sequence returns `ack`. The device registers and the entry sequence are outside this block.

Top module: `irq_vector_unit`

## Requirements
- R1: A device is a candidate only when its `dev_ready` bit and its `dev_enable` bit are both 1. A device with either bit at 0 never drives the outputs.
- R2: Among the candidates, the device with the numerically highest level (field i of `dev_level`, bits [3i+2:3i]) wins.
- R3: When several candidates share the highest level, the one with the lowest device index wins.
- R4: `int_req` is 1 in the same cycle exactly when a winner exists and its level is strictly greater than `run_level`. It is 0 when the levels are equal and when there is no candidate.
- R5: `take` is 1 exactly when `fetch_first` and `int_req` are both 1 and `irq_pending` is 0.
- R6: After a cycle with `take` at 1, `irq_pending` is 1 from the next cycle on, and `irq_vector` and `irq_level` show the vector (field i of `dev_vector`, bits [8i+7:8i]) and the level of the winner from the take cycle.
- R7: While `irq_pending` is 1, `irq_vector` and `irq_level` do not change and no new take happens. An `ack` clears `irq_pending` in the next cycle.
- R8: With no take, `irq_vector` and `irq_level` keep their last values. `ack` has no effect while nothing is pending.
- R9: During reset, `irq_pending`, `irq_vector` and `irq_level` are 0.
- R10: Requests are level-sensitive. A request that drops before the fetch cycle is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_ready | input | N_DEV | Per-device ready flags |
| dev_enable | input | N_DEV | Per-device interrupt enable flags |
| dev_level | input | N_DEV*LVL_W | Packed per-device priority levels |
| dev_vector | input | N_DEV*VEC_W | Packed per-device vectors |
| run_level | input | LVL_W | Priority level of the running program |
| fetch_first | input | 1 | First cycle of instruction fetch |
| ack | input | 1 | Entry sequence has consumed the held vector |
| int_req | output | 1 | A candidate outranks the running program |
| take | output | 1 | Interrupt accepted at this fetch boundary |
| irq_pending | output | 1 | Held vector waiting for acknowledge |
| irq_vector | output | VEC_W | Held vector of the accepted request |
| irq_level | output | LVL_W | Held level of the accepted request |

## Verification
On every cycle the assertions check the following: that any winner is a qualified device, that no candidate outranks the winner, that a tied candidate never has a lower index, that requests are strict against the running level, that take happens only at an unpended fetch boundary, and that the held vector loads, holds and clears as required. Some behaviours are sequences and show only in the bench's scenarios. These are a request that drops just before fetch, an ack arriving while nothing is pending, and the exact vector a tie resolves to. The bench also runs a pseudo-random stream compared cycle by cycle against a behavioural model.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // True when a candidate displaces the current best: strictly higher level.
  // A tie keeps the earlier (lower index) holder.
  function automatic logic outranks(input logic cand_q, input logic [15:0] cand_l,
                                    input logic best_q, input logic [15:0] best_l);
    return cand_q && (!best_q || (cand_l > best_l));
  endfunction

  // Request is raised only for a level strictly above the running program.
  function automatic logic above_run(input logic win_q, input logic [15:0] win_l,
                                     input logic [15:0] run_l);
    return win_q && (win_l > run_l);
  endfunction

endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int N_DEV = 4
) (
  input  logic [N_DEV-1:0] dev_ready,
  input  logic [N_DEV-1:0] dev_enable,
  output logic [N_DEV-1:0] qual
);
  for (genvar i = 0; i < N_DEV; i++) begin : g_q
    assign qual[i] = dev_ready[i] & dev_enable[i];
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_DEV = 4,
  parameter int LVL_W = 3,
  parameter int VEC_W = 8,
  localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_DEV-1:0]       qual,
  input  logic [N_DEV*LVL_W-1:0] dev_level,
  input  logic [N_DEV*VEC_W-1:0] dev_vector,
  output logic                   win_valid,
  output logic [IDX_W-1:0]       win_idx,
  output logic [LVL_W-1:0]       win_level,
  output logic [VEC_W-1:0]       win_vector
);
  logic             bv [N_DEV+1];
  logic [IDX_W-1:0] bi [N_DEV+1];
  logic [LVL_W-1:0] bl [N_DEV+1];
  logic [VEC_W-1:0] bx [N_DEV+1];

  assign bv[0] = 1'b0;
  assign bi[0] = '0;
  assign bl[0] = '0;
  assign bx[0] = '0;

  for (genvar i = 0; i < N_DEV; i++) begin : g_chain
    logic [LVL_W-1:0] lvl_i;
    logic [VEC_W-1:0] vec_i;
    logic             repl;
    assign lvl_i = dev_level[i*LVL_W +: LVL_W];
    assign vec_i = dev_vector[i*VEC_W +: VEC_W];
    assign repl  = outranks(qual[i], 16'(lvl_i), bv[i], 16'(bl[i]));
    assign bv[i+1] = bv[i] | qual[i];
    assign bi[i+1] = repl ? IDX_W'(i) : bi[i];
    assign bl[i+1] = repl ? lvl_i : bl[i];
    assign bx[i+1] = repl ? vec_i : bx[i];

    // R2: no qualified device holds a level above the winner
    a_r2_no_higher: assert property (@(posedge clk) disable iff (!rst_n)
      qual[i] |-> (win_valid && (win_level >= lvl_i)));
    // R3: a tied qualified device is never ahead of the winner by index
    a_r3_tie_low_index: assert property (@(posedge clk) disable iff (!rst_n)
      (qual[i] && (lvl_i == win_level)) |-> (win_idx <= IDX_W'(i)));
  end

  assign win_valid  = bv[N_DEV];
  assign win_idx    = bi[N_DEV];
  assign win_level  = bl[N_DEV];
  assign win_vector = bx[N_DEV];
endmodule

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int LVL_W = 3,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             ack,
  input  logic [LVL_W-1:0] win_level,
  input  logic [VEC_W-1:0] win_vector,
  output logic             pend,
  output logic [VEC_W-1:0] vec,
  output logic [LVL_W-1:0] lvl
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      vec  <= '0;
      lvl  <= '0;
    end else if (take) begin
      pend <= 1'b1;
      vec  <= win_vector;
      lvl  <= win_level;
    end else if (ack) begin
      pend <= 1'b0;
    end
  end

  // R6: a take loads the winner and sets pending
  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (pend && (vec == $past(win_vector)) && (lvl == $past(win_level))));
  // R7: pending without ack stays pending
  a_r7_hold_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ack) |=> pend);
  // R7: ack clears pending
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && ack) |=> !pend);
  // R8: without a take the held vector and level do not move
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(vec) && $stable(lvl)));
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_pkg::*;
#(
  parameter int N_DEV = 4,
  parameter int LVL_W = 3,
  parameter int VEC_W = 8,
  localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_DEV-1:0]       dev_ready,
  input  logic [N_DEV-1:0]       dev_enable,
  input  logic [N_DEV*LVL_W-1:0] dev_level,
  input  logic [N_DEV*VEC_W-1:0] dev_vector,
  input  logic [LVL_W-1:0]       run_level,
  input  logic                   fetch_first,
  input  logic                   ack,
  output logic                   int_req,
  output logic                   take,
  output logic                   irq_pending,
  output logic [VEC_W-1:0]       irq_vector,
  output logic [LVL_W-1:0]       irq_level
);
  logic [N_DEV-1:0] qual;
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;
  logic [LVL_W-1:0] win_level;
  logic [VEC_W-1:0] win_vector;

  irq_qualify #(.N_DEV(N_DEV)) u_qual (
    .dev_ready (dev_ready),
    .dev_enable(dev_enable),
    .qual      (qual)
  );

  irq_arbiter #(.N_DEV(N_DEV), .LVL_W(LVL_W), .VEC_W(VEC_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .qual      (qual),
    .dev_level (dev_level),
    .dev_vector(dev_vector),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_level (win_level),
    .win_vector(win_vector)
  );

  assign int_req = above_run(win_valid, 16'(win_level), 16'(run_level));
  assign take    = fetch_first & int_req & ~irq_pending;

  irq_capture #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .ack       (ack),
    .win_level (win_level),
    .win_vector(win_vector),
    .pend      (irq_pending),
    .vec       (irq_vector),
    .lvl       (irq_level)
  );

  // R1: the winner is a device with both flags set
  a_r1_winner_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (dev_ready[win_idx] && dev_enable[win_idx]));
  // R4: a raised request is strictly above the running level
  a_r4_strict: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (win_valid && (win_level > run_level)));
  // R5: acceptance only at an unpended fetch boundary
  a_r5_take_gate: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (fetch_first && !irq_pending));
endmodule

// File: tb/tb_irq_vector_unit.sv
`timescale 1ns/1ps
module tb_irq_vector_unit;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] rdy = '0, en = '0;
  logic [2:0] lv [N];
  logic [7:0] vc [N];
  logic [2:0] run_lvl = '0;
  logic fetch = 1'b0, ackq = 1'b0;
  logic [N*3-1:0] lv_flat;
  logic [N*8-1:0] vc_flat;
  logic int_req, take, irq_pending;
  logic [7:0] irq_vector;
  logic [2:0] irq_level;

  int checks = 0, errors = 0;
  int e_pend = 0, e_vec = 0, e_lvl = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      lv_flat[i*3 +: 3] = lv[i];
      vc_flat[i*8 +: 8] = vc[i];
    end
  end

  irq_vector_unit #(.N_DEV(N), .LVL_W(3), .VEC_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .dev_ready(rdy), .dev_enable(en),
    .dev_level(lv_flat), .dev_vector(vc_flat), .run_level(run_lvl),
    .fetch_first(fetch), .ack(ackq), .int_req(int_req), .take(take),
    .irq_pending(irq_pending), .irq_vector(irq_vector), .irq_level(irq_level));

  // Scan levels from the top; the first device found at a level is the lowest index.
  function automatic int ref_winner();
    for (int l = 7; l >= 0; l--)
      for (int i = 0; i < N; i++)
        if (rdy[i] && en[i] && int'(lv[i]) == l) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    int w;
    int e_int, e_take;
    @(negedge clk);
    w = ref_winner();
    e_int  = (w >= 0 && int'(lv[w]) > int'(run_lvl)) ? 1 : 0;
    e_take = (fetch && e_int == 1 && e_pend == 0) ? 1 : 0;
    if (rst_n) begin
      chk(tag, "int_req", int'(int_req), e_int);
      chk(tag, "take", int'(take), e_take);
    end
    chk(tag, "pending", int'(irq_pending), e_pend);
    chk(tag, "vector", int'(irq_vector), e_vec);
    chk(tag, "level", int'(irq_level), e_lvl);
    if (!rst_n) begin
      e_pend = 0; e_vec = 0; e_lvl = 0;
    end else if (e_take == 1) begin
      e_pend = 1; e_vec = int'(vc[w]); e_lvl = int'(lv[w]);
    end else if (ackq) begin
      e_pend = 0;
    end
    @(posedge clk); #1;
  endtask

  task automatic idle_inputs();
    rdy = '0; en = '0; fetch = 0; ackq = 0; run_lvl = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lfsr;
    for (int i = 0; i < N; i++) begin
      lv[i] = 3'(i);
      vc[i] = 8'(8'h40 + 8'(i) * 8'h11);
    end
    // R9: reset state
    repeat (3) step("R9");
    rst_n = 1;
    step("R9");
    // R4: no candidate, no request
    step("R4");
    // R1: ready without enable, enable without ready
    lv[1] = 3'd5; rdy = 4'b0010; en = 4'b0000; fetch = 1; step("R1");
    rdy = 4'b0000; en = 4'b0010; step("R1");
    fetch = 0;
    // R5/R6: keyboard-like level 4 on device 2, wait then fetch
    lv[2] = 3'd4; rdy = 4'b0100; en = 4'b0100; step("R5");
    fetch = 1; step("R5");
    fetch = 0; step("R6");
    chk("R6", "held vector", int'(irq_vector), 8'h62);
    // R7: while pending, a more urgent request and a fetch are not taken
    lv[3] = 3'd7; rdy = 4'b1100; en = 4'b1100; fetch = 1; step("R7");
    step("R7");
    ackq = 1; fetch = 0; step("R7");
    ackq = 0; step("R7");
    chk("R7", "cleared", int'(irq_pending), 0);
    // R2: highest level wins
    lv[1] = 3'd6; lv[3] = 3'd7; rdy = 4'b1010; en = 4'b1010; fetch = 1; step("R2");
    fetch = 0; step("R2");
    chk("R2", "winner vector", int'(irq_vector), 8'h73);
    ackq = 1; step("R2"); ackq = 0;
    // R3: tie at level 5 between devices 0 and 2
    lv[0] = 3'd5; lv[2] = 3'd5; rdy = 4'b0101; en = 4'b0101; fetch = 1; step("R3");
    fetch = 0; step("R3");
    chk("R3", "tie vector", int'(irq_vector), 8'h40);
    ackq = 1; step("R3"); ackq = 0;
    // R4: equal level is not enough, one below is
    run_lvl = 3'd5; step("R4");
    chk("R4", "equal level", int'(int_req), 0);
    run_lvl = 3'd4; step("R4");
    chk("R4", "one below", int'(int_req), 1);
    // R10/R8: request drops just before fetch; vector holds; ack ignored
    rdy = 4'b0000; fetch = 1; ackq = 1; step("R10");
    fetch = 0; ackq = 0; step("R8");
    chk("R8", "vector kept", int'(irq_vector), 8'h40);
    idle_inputs();
    // Pseudo-random stream against the model
    lfsr = 16'hACE1;
    for (int c = 0; c < 400; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rdy = lfsr[3:0]; en = lfsr[7:4] | lfsr[11:8];
      lv[c % N] = lfsr[14:12];
      run_lvl = lfsr[10:8] & 3'(lfsr[2:1]);
      fetch = lfsr[5] & lfsr[9];
      ackq = lfsr[15] & lfsr[0];
      step("R2R3");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule